// File: doc/BRIEF.md
# Debug Scan Data Register Bank

This block sits behind a test access port and provides the data registers that an on-chip debugger reaches through it. A TAP controller outside the block supplies a decoded controller state and the current instruction. The block then routes TDI through the selected register and returns the bit leaving that register on TDO.

Three kinds of register are selectable:
- a one-bit bypass stage;
- a mask scan register, whose parallel side is a debug-mask register;
- a chain of 16-bit stages, where each stage captures from and updates its own bus-visible word.

A separate instruction produces a one-TCK debugger-reset pulse.

Shifting and capture happen on the rising edge of TCK. Parallel updates, TDO and the reset pulse change on the falling edge of TCK. A bus-side write strobe can overwrite any mapped word. When that write falls in the same falling-edge slot as a scan update, the bus write wins.

Top module: `dbg_scan_bank`

## Requirements
- R1: With instruction code 0 (bypass) or 2 (debugger reset), the serial path is a single stage. In Capture-DR it loads 0, so TDO shows 0 first and then each TDI bit one shift later.
- R2: In Shift-DR (state code 3), the selected register moves one place toward TDO on each rising edge of TCK, with TDI entering at the most significant end. On each falling edge, TDO takes the least significant bit of the selected register, without inversion.
- R3: On each falling edge, `tdo_oe` is set high if the state is Shift-DR and low otherwise.
- R4: With instruction code 1 (mask scan), Capture-DR (state code 2) loads the scan register from the current debug-mask value. The debug mask itself does not change.
- R5: With instruction code 1, the falling edge of TCK in Update-DR (state code 7) copies the scan register into the debug mask. The scan register keeps its value.
- R6: With instruction code 3 (word scan), the serial path is N stages of 16 bits. Stage k holds word k, and stage N-1 sits at the TDI end. Inside each stage, bit 15 faces TDI and bit 0 faces TDO. Word k occupies bits [16k+15:16k] of `words`.
- R7: With instruction code 3, Capture-DR loads every stage from its word. On the Update-DR falling edge, every word is loaded from its stage.
- R8: A bus write strobe writes `bus_wdata` into word `bus_addr` on the falling edge of TCK. If a scan update of the words happens on the same edge, the bus value is what that word takes.
- R9: `dbg_rst` is high for exactly one TCK period, starting at the Update-DR falling edge under instruction code 2. It never goes high under any other instruction.
- R10: In Exit1-DR (4), Pause-DR (5), Exit2-DR (6), Run-Test/Idle (1), and for every register that the instruction does not select, all scan and parallel registers keep their values.
- R11: While reset is high, every register and output is cleared to zero on both TCK edges. In Test-Logic-Reset (state code 0), no register captures, shifts or updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; shifts on rise, updates on fall |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial data in |
| tap_state | input | 3 | Decoded TAP controller state code |
| instr | input | 2 | Current instruction code |
| bus_we | input | 1 | Bus-side word write strobe |
| bus_addr | input | ADDR_W | Word index of the bus write |
| bus_wdata | input | WORD_W | Bus write data |
| tdo | output | 1 | Serial data out, registered on falling edge |
| tdo_oe | output | 1 | TDO output enable, high in Shift-DR |
| dbg_rst | output | 1 | One-period debugger-reset pulse |
| dbg_mask | output | MASK_W | Debug-mask register |
| words | output | NUM_WORDS*WORD_W | All mapped words, word k at bits [16k+15:16k] |

## Verification
Suppose a scan stage holds a wrong value. It stays hidden until that bit reaches the TDO end, which takes at most the length of the selected chain in shifts. It also appears one falling edge after the next Update-DR, when the wrong value lands in `dbg_mask` or `words`. Any corruption of a parallel register is visible on the port at the falling edge where it happens. For that reason, the bench compares every output against a queue-based model on every TCK period. It also runs long pause windows and bus writes that collide with updates, so that a stale or reordered stage is caught within one scan.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

  typedef enum logic [2:0] {
    ST_TLRESET = 3'd0,
    ST_IDLE    = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_SHIFT   = 3'd3,
    ST_EXIT1   = 3'd4,
    ST_PAUSE   = 3'd5,
    ST_EXIT2   = 3'd6,
    ST_UPDATE  = 3'd7
  } tap_state_e;

  typedef enum logic [1:0] {
    IN_BYPASS = 2'd0,
    IN_MASK   = 2'd1,
    IN_DBGRST = 2'd2,
    IN_WORDS  = 2'd3
  } scan_instr_e;

endpackage

// File: rtl/dbg_dr_shift.sv
// Capture/shift stage of one data register; rising-edge domain.
module dbg_dr_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic         sin,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] sr_o
);

  logic [W-1:0] sr_q;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (cap_en)   sr_q <= par_in;
        else if (shift_en) sr_q <= sin;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (cap_en)   sr_q <= par_in;
        else if (shift_en) sr_q <= {sin, sr_q[W-1:1]};
      end
    end
  endgenerate

  assign sr_o = sr_q;

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst)
    ($past(cap_en) && !$past(rst)) |-> (sr_q == $past(par_in))); // R4

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ($past(shift_en) && !$past(cap_en) && !$past(rst)) |-> (sr_q[W-1] == $past(sin))); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(shift_en) && !$past(cap_en) && !$past(rst)) |-> $stable(sr_q)); // R10

endmodule

// File: rtl/dbg_word_bank.sv
// Bus-visible words updated from the scan chain on the falling edge.
module dbg_word_bank #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        upd_en,
  input  logic [NUM_WORDS*WORD_W-1:0] chain_in,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [NUM_WORDS*WORD_W-1:0] words_o
);

  logic [WORD_W-1:0] word_q [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic hit;
    assign hit = bus_we && (int'(bus_addr) == k);

    always_ff @(negedge clk) begin
      if (rst)         word_q[k] <= '0;
      else if (hit)    word_q[k] <= bus_wdata;
      else if (upd_en) word_q[k] <= chain_in[k*WORD_W +: WORD_W];
    end

    assign words_o[k*WORD_W +: WORD_W] = word_q[k];
  end

  AST_BUS_WINS: assert property (@(negedge clk) disable iff (rst)
    ($past(bus_we) && !$past(rst) && (int'($past(bus_addr)) < NUM_WORDS))
      |-> (word_q[$past(bus_addr)] == $past(bus_wdata))); // R8

  AST_WORDS_HOLD: assert property (@(negedge clk) disable iff (rst)
    (!$past(bus_we) && !$past(upd_en) && !$past(rst)) |-> $stable(words_o)); // R10

endmodule

// File: rtl/dbg_scan_bank.sv
module dbg_scan_bank
  import dbg_scan_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int MASK_W    = 8,
  parameter int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        tck,
  input  logic                        rst,
  input  logic                        tdi,
  input  logic [2:0]                  tap_state,
  input  logic [1:0]                  instr,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic                        tdo,
  output logic                        tdo_oe,
  output logic                        dbg_rst,
  output logic [MASK_W-1:0]           dbg_mask,
  output logic [NUM_WORDS*WORD_W-1:0] words
);

  localparam int CHAIN_W = NUM_WORDS * WORD_W;

  logic in_cap, in_shift, in_upd;
  logic sel_byp, sel_mask, sel_words;

  assign in_cap    = (tap_state == ST_CAPTURE);
  assign in_shift  = (tap_state == ST_SHIFT);
  assign in_upd    = (tap_state == ST_UPDATE);
  assign sel_mask  = (instr == IN_MASK);
  assign sel_words = (instr == IN_WORDS);
  assign sel_byp   = !sel_mask && !sel_words;

  // bypass stage
  logic byp_sr;
  dbg_dr_shift #(.W(1)) i_byp (
    .clk(tck), .rst(rst),
    .cap_en(in_cap && sel_byp), .shift_en(in_shift && sel_byp),
    .sin(tdi), .par_in(1'b0), .sr_o(byp_sr)
  );

  // mask scan register and its parallel side
  logic [MASK_W-1:0] mask_sr;
  logic [MASK_W-1:0] mask_q;
  dbg_dr_shift #(.W(MASK_W)) i_mask_sr (
    .clk(tck), .rst(rst),
    .cap_en(in_cap && sel_mask), .shift_en(in_shift && sel_mask),
    .sin(tdi), .par_in(mask_q), .sr_o(mask_sr)
  );

  always_ff @(negedge tck) begin
    if (rst)                  mask_q <= '0;
    else if (in_upd && sel_mask) mask_q <= mask_sr;
  end

  // word chain: stage NUM_WORDS-1 at TDI, stage 0 at TDO
  logic [CHAIN_W-1:0] chain_sr;
  logic [NUM_WORDS*WORD_W-1:0] words_int;

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_stage
    logic stage_sin;
    if (k == NUM_WORDS - 1) begin : g_head
      assign stage_sin = tdi;
    end else begin : g_link
      assign stage_sin = chain_sr[(k+1)*WORD_W];
    end
    dbg_dr_shift #(.W(WORD_W)) i_stage (
      .clk(tck), .rst(rst),
      .cap_en(in_cap && sel_words), .shift_en(in_shift && sel_words),
      .sin(stage_sin), .par_in(words_int[k*WORD_W +: WORD_W]),
      .sr_o(chain_sr[k*WORD_W +: WORD_W])
    );
  end

  dbg_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_bank (
    .clk(tck), .rst(rst),
    .upd_en(in_upd && sel_words), .chain_in(chain_sr),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .words_o(words_int)
  );

  // falling-edge outputs
  logic tdo_q, oe_q, dbgrst_q;
  logic lsb_sel;

  always_comb begin
    case (instr)
      IN_MASK:  lsb_sel = mask_sr[0];
      IN_WORDS: lsb_sel = chain_sr[0];
      default:  lsb_sel = byp_sr;
    endcase
  end

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      dbgrst_q <= 1'b0;
    end else begin
      tdo_q    <= lsb_sel;
      oe_q     <= in_shift;
      dbgrst_q <= in_upd && (instr == IN_DBGRST);
    end
  end

  assign tdo      = tdo_q;
  assign tdo_oe   = oe_q;
  assign dbg_rst  = dbgrst_q;
  assign dbg_mask = mask_q;
  assign words    = words_int;

  AST_OE_ONLY_SHIFT: assert property (@(negedge tck) disable iff (rst)
    (oe_q && !$past(rst)) |-> ($past(tap_state) == ST_SHIFT)); // R3

  AST_DBGRST_SOURCE: assert property (@(negedge tck) disable iff (rst)
    (dbgrst_q && !$past(rst)) |-> ($past(instr) == IN_DBGRST && $past(tap_state) == ST_UPDATE)); // R9

  AST_MASK_HOLD: assert property (@(negedge tck) disable iff (rst)
    (!$past(rst) && !($past(tap_state) == ST_UPDATE && $past(instr) == IN_MASK))
      |-> $stable(mask_q)); // R10

endmodule

// File: tb/test_dbg_scan_bank.sv
`timescale 1ns/100ps
module test_dbg_scan_bank;
  import dbg_scan_pkg::*;

  localparam int N  = 4;
  localparam int WW = 16;
  localparam int MW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tdi = 1'b0;
  logic [2:0] st = 3'd1;
  logic [1:0] ir = 2'd0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [WW-1:0] bus_wdata = '0;
  logic tdo, tdo_oe, dbg_rst;
  logic [MW-1:0] dbg_mask;
  logic [N*WW-1:0] words;

  always #2.5 clk = ~clk;

  dbg_scan_bank #(.NUM_WORDS(N), .WORD_W(WW), .MASK_W(MW)) i_dbg_scan_bank (
    .tck(clk), .rst(rst), .tdi(tdi), .tap_state(st), .instr(ir),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tdo(tdo), .tdo_oe(tdo_oe), .dbg_rst(dbg_rst),
    .dbg_mask(dbg_mask), .words(words)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R11";

  // behavioural model: queues, element 0 is the TDO end
  bit mq[$];
  bit cq[$];
  bit bq;
  logic [MW-1:0] m_mask;
  logic [WW-1:0] m_words [N];
  logic m_tdo, m_oe, m_dbg;

  function automatic bit model_lsb();
    if (ir == 2'd1) return mq[0];
    if (ir == 2'd3) return cq[0];
    return bq;
  endfunction

  task automatic model_neg();
    if (rst) begin
      m_mask = '0; m_tdo = 0; m_oe = 0; m_dbg = 0;
      foreach (m_words[k]) m_words[k] = '0;
    end else begin
      m_tdo = model_lsb();
      m_oe  = (st == 3'd3);
      m_dbg = (st == 3'd7) && (ir == 2'd2);
      if (st == 3'd7 && ir == 2'd1)
        for (int b = 0; b < MW; b++) m_mask[b] = mq[b];
      if (st == 3'd7 && ir == 2'd3)
        for (int b = 0; b < N*WW; b++) m_words[b/WW][b%WW] = cq[b];
      if (bus_we) m_words[bus_addr] = bus_wdata;
    end
  endtask

  task automatic model_pos();
    if (rst) begin
      mq.delete(); cq.delete(); bq = 0;
      for (int b = 0; b < MW; b++) mq.push_back(1'b0);
      for (int b = 0; b < N*WW; b++) cq.push_back(1'b0);
    end else if (st == 3'd2) begin
      if (ir == 2'd1) for (int b = 0; b < MW; b++) mq[b] = m_mask[b];
      else if (ir == 2'd3) for (int b = 0; b < N*WW; b++) cq[b] = m_words[b/WW][b%WW];
      else bq = 1'b0;
    end else if (st == 3'd3) begin
      if (ir == 2'd1) begin void'(mq.pop_front()); mq.push_back(tdi); end
      else if (ir == 2'd3) begin void'(cq.pop_front()); cq.push_back(tdi); end
      else bq = tdi;
    end
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [N*WW-1:0] ew;
    for (int k = 0; k < N; k++) ew[k*WW +: WW] = m_words[k];
    chk("tdo (R2)", 64'(tdo), 64'(m_tdo));
    chk("tdo_oe (R3)", 64'(tdo_oe), 64'(m_oe));
    chk("dbg_rst (R9)", 64'(dbg_rst), 64'(m_dbg));
    chk("dbg_mask (R5)", 64'(dbg_mask), 64'(m_mask));
    chk("words (R7)", 64'(words), 64'(ew));
  endtask

  task automatic step(input logic [2:0] s, input logic [1:0] i, input logic d);
    st = s; ir = i; tdi = d;
    @(negedge clk);
    model_neg();
    #1 compare();
    @(posedge clk);
    model_pos();
    bus_we = 1'b0;
    #0.5;
  endtask

  task automatic scan(input logic [1:0] i, input logic [63:0] val, input int n);
    step(3'd2, i, 1'b0);
    for (int b = 0; b < n; b++) step(3'd3, i, val[b]);
    step(3'd4, i, 1'b0);
    step(3'd7, i, 1'b0);
    step(3'd1, i, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #0.5;
    // R11: reset clears everything
    tag = "R11";
    for (int c = 0; c < 3; c++) step(3'd1, 2'd0, 1'b1);
    rst = 1'b0;
    step(3'd1, 2'd0, 1'b0);

    // R8: bus writes to every word
    tag = "R8";
    for (int k = 0; k < N; k++) begin
      bus_we = 1'b1; bus_addr = 2'(k); bus_wdata = 16'h1111 * 16'(k + 1) ^ 16'h8001;
      step(3'd1, 2'd0, 1'b0);
    end

    // R4 R5: mask scan loads, then updates
    tag = "R5";
    scan(2'd1, 64'hA5, MW);
    tag = "R4";
    // capture old mask, shift with a long pause in the middle (R10)
    step(3'd2, 2'd1, 1'b0);
    for (int b = 0; b < 3; b++) step(3'd3, 2'd1, b[0]);
    step(3'd4, 2'd1, 1'b1);
    tag = "R10";
    for (int b = 0; b < 6; b++) step(3'd5, 2'd1, 1'b1);
    step(3'd6, 2'd1, 1'b0);
    tag = "R4";
    for (int b = 3; b < MW; b++) step(3'd3, 2'd1, 1'b1);
    step(3'd4, 2'd1, 1'b0);
    step(3'd7, 2'd1, 1'b0);
    step(3'd1, 2'd1, 1'b0);

    // R6 R7: word chain capture then full scan update
    tag = "R6";
    scan(2'd3, 64'h0123_4567_89AB_CDEF, N*WW);
    tag = "R7";
    scan(2'd3, 64'hFEDC_0F0F_3C3C_5AA5, N*WW);

    // R8: bus write collides with the scan update on word 2
    tag = "R8";
    step(3'd2, 2'd3, 1'b0);
    for (int b = 0; b < N*WW; b++) step(3'd3, 2'd3, 1'($urandom));
    step(3'd4, 2'd3, 1'b0);
    bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 16'hBEEF;
    step(3'd7, 2'd3, 1'b0);
    step(3'd1, 2'd3, 1'b0);

    // R1: bypass captures 0 and delays by one
    tag = "R1";
    step(3'd2, 2'd0, 1'b1);
    for (int b = 0; b < 10; b++) step(3'd3, 2'd0, 1'($urandom));
    step(3'd4, 2'd0, 1'b0);
    step(3'd7, 2'd0, 1'b0);  // R9: no pulse under bypass
    step(3'd1, 2'd0, 1'b0);

    // R9: debugger reset pulse through bypass path
    tag = "R9";
    step(3'd2, 2'd2, 1'b1);
    for (int b = 0; b < 5; b++) step(3'd3, 2'd2, 1'($urandom));
    step(3'd4, 2'd2, 1'b0);
    step(3'd7, 2'd2, 1'b0);
    step(3'd1, 2'd2, 1'b0);
    step(3'd1, 2'd2, 1'b0);

    // R11: Test-Logic-Reset does nothing under any instruction; R10 unselected hold
    tag = "R11";
    for (int i = 0; i < 4; i++) step(3'd0, 2'(i), 1'b1);
    tag = "R10";
    for (int i = 0; i < 4; i++) step(3'd6, 2'(i), 1'b1);

    // random sequences of states and instructions
    tag = "R2";
    for (int c = 0; c < 1500; c++) begin
      if (($urandom % 8) == 0) begin
        bus_we = 1'b1; bus_addr = 2'($urandom); bus_wdata = 16'($urandom);
      end
      step(3'($urandom), 2'($urandom), 1'($urandom));
    end

    // R11: reset in mid run
    tag = "R11";
    rst = 1'b1;
    step(3'd3, 2'd3, 1'b1);
    step(3'd7, 2'd1, 1'b1);
    rst = 1'b0;
    step(3'd1, 2'd0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule